// File: doc/BRIEF.md
# Code Protection Security Register

This block keeps the byte of protection settings for an on-chip code store and applies the access rules those settings call for. The byte is treated as one-time-clearable. With the programming mode input high, a program operation aimed at the register address can only take bits from 1 to 0. A whole-chip erase is the only path back to all ones. Outside programming mode the register cannot be read or written at all.

Four bit positions are implemented, and each is active when 0:
- a lock bit, which makes every programming-mode read return invalid data;
- a table-read inhibit bit;
- an encryption enable bit;
- an oscillator half-gain bit.

The other positions are reserved and always read as 1. In normal mode the block judges each code-table read by two things: the address of the instruction making the read, and the address the read targets. It then passes the fetched byte through, or replaces it with FFh and raises a one-cycle violation flag. The encryption and gain bits leave the block as active-high control outputs for the logic that uses them.

Top module: `codeguard_secreg`

## Requirements
- R1: After reset the register holds FFh. A programming-mode read at address FFFFh returns FFh, `lock_o`, `enc_en_o` and `half_gain_o` are 0, and `tr_valid_o` is 0.
- R2: A program operation (`prog_mode_i`=1, `pm_wr_i`=1, `pm_addr_i`=FFFFh, register unlocked) ANDs `pm_wdata_i` into the register on that clock edge. A 1 in the written byte never sets a bit.
- R3: With `prog_mode_i`=1, `pm_erase_i`=1 sets every register bit to 1 on the next clock edge. This holds even when the register is locked, and erase wins over a write in the same cycle.
- R4: Only bits 0, 1, 2 and 7 are stored. Bits 3 to 6 always read back as 1, whatever is written.
- R5: The register is left unchanged by any write or erase while `prog_mode_i`=0, by a write to any address other than FFFFh, and by a write while the lock bit (bit 0) is 0.
- R6: While the lock bit is 0, every programming-mode read returns FFh on `pm_rdata_o`, for the register address and for code array addresses alike.
- R7: While unlocked in programming mode, `pm_rdata_o` shows the register when `pm_addr_i`=FFFFh and `pm_array_i` at any other address, in the same cycle. Outside programming mode `pm_rdata_o` is FFh.
- R8: A table read is accepted when `tr_req_i`=1 and `prog_mode_i`=0. One cycle later `tr_valid_o` pulses for one cycle with the result. A read whose executing address `tr_pc_i` lies in the internal region 0000h..1FFFh is always allowed and returns the `tr_data_i` captured with the request.
- R9: When table-read inhibit (bit 1) is 0, a read executing from `tr_pc_i` > 1FFFh that targets `tr_addr_i` <= 1FFFh is blocked. The result is `tr_data_o`=FFh with `tr_viol_o`=1 in the `tr_valid_o` cycle.
- R10: When inhibit is 0, a read executing externally that targets an address above 1FFFh is allowed, with `tr_viol_o`=0.
- R11: When inhibit is 1, every table read is allowed whatever the two addresses are.
- R12: `tr_viol_o` is only ever 1 together with `tr_valid_o`.
- R13: A table request made while `prog_mode_i`=1 is ignored and produces no `tr_valid_o` pulse.
- R14: `lock_o`, `enc_en_o` and `half_gain_o` are the inverses of register bits 0, 2 and 7. They follow the register in the cycle after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, loads the erased state |
| prog_mode_i | input | 1 | 1 selects programming mode |
| pm_addr_i | input | 16 | Programming-mode address |
| pm_wr_i | input | 1 | Program operation strobe |
| pm_wdata_i | input | 8 | Byte ANDed into the register |
| pm_erase_i | input | 1 | Whole-chip erase strobe |
| pm_array_i | input | 8 | Byte read from the code array at `pm_addr_i` |
| pm_rdata_o | output | 8 | Programming-mode read data |
| tr_req_i | input | 1 | Table read request |
| tr_pc_i | input | 16 | Address of the instruction doing the table read |
| tr_addr_i | input | 16 | Target address of the table read |
| tr_data_i | input | 8 | Byte fetched at the target address |
| tr_valid_o | output | 1 | Table read result valid, one cycle after the request |
| tr_data_o | output | 8 | Table read result, FFh when blocked |
| tr_viol_o | output | 1 | Access violation pulse |
| lock_o | output | 1 | Code is locked |
| enc_en_o | output | 1 | Encryption enabled |
| half_gain_o | output | 1 | Oscillator runs at half gain |

## Verification
A stored bit that is wrong shows at once on the status outputs and on a register read at FFFFh, one edge after the operation that caused it. A wrongly kept lock is different: it shows as FFh on array reads in the very next programming-mode cycle. A wrong inhibit bit or a wrong region compare gives no sign until an externally executed table read targets internal code. It then appears one cycle after that request, as a byte passed through when FFh was due, or the reverse, with `tr_viol_o` out of step. For this reason the table reads are placed right at the 1FFFh/2000h boundary, on both addresses.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

   // Result of one judged table read as it leaves the gate stage.
   typedef struct packed {
      logic       valid;
      logic       viol;
      logic [7:0] data;
   } tr_result_t;

   // True when an address falls at or below the top of the internal region.
   function automatic logic in_internal(input logic [15:0] addr, input logic [15:0] top);
      return addr <= top;
   endfunction

endpackage

// File: rtl/secreg_store.sv
module secreg_store #(
   parameter int              DATA_W    = 8,
   parameter int              ADDR_W    = 16,
   parameter logic [DATA_W-1:0] IMPL_MASK = 8'h87,
   parameter logic [ADDR_W-1:0] SEC_ADDR  = 16'hFFFF,
   parameter int              LOCK_POS  = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              prog_mode_i,
   input  logic              wr_i,
   input  logic              erase_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] sec_o
);

   localparam logic [DATA_W-1:0] RSVD_ONES = ~IMPL_MASK;

   logic              erase_hit;
   logic              wr_hit;
   logic [DATA_W-1:0] cleared;

   assign erase_hit = prog_mode_i && erase_i;
   assign wr_hit    = prog_mode_i && wr_i && (addr_i == SEC_ADDR) && sec_o[LOCK_POS];
   assign cleared   = (sec_o & wdata_i) | RSVD_ONES;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      if (IMPL_MASK[i]) begin : g_cell
         logic q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)        q <= 1'b1;
            else if (erase_hit) q <= 1'b1;
            else if (wr_hit)    q <= cleared[i];
         end
         assign sec_o[i] = q;
      end else begin : g_rsvd
         assign sec_o[i] = 1'b1;
      end
   end

   // R2: without erase no stored bit moves from 0 to 1
   p_no_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(prog_mode_i && erase_i) |=> ((sec_o & ~$past(sec_o)) == '0));

   // R3: erase in programming mode leaves all ones
   p_erase_ones_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_mode_i && erase_i) |=> (sec_o == '1));

   // R5: nothing changes outside programming mode
   p_frozen_normal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !prog_mode_i |=> $stable(sec_o));

   // R5: a locked register only leaves its value through erase
   p_locked_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_mode_i && !sec_o[LOCK_POS] && !erase_i) |=> $stable(sec_o));

endmodule

// File: rtl/secreg_pm_read.sv
module secreg_pm_read #(
   parameter int              DATA_W   = 8,
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] SEC_ADDR = 16'hFFFF,
   parameter int              LOCK_POS = 0
) (
   input  logic              prog_mode_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] sec_i,
   input  logic [DATA_W-1:0] array_i,
   output logic [DATA_W-1:0] rdata_o
);

   always_comb begin
      if (!prog_mode_i || !sec_i[LOCK_POS]) rdata_o = '1;
      else if (addr_i == SEC_ADDR)          rdata_o = sec_i;
      else                                  rdata_o = array_i;
   end

endmodule

// File: rtl/secreg_tr_gate.sv
module secreg_tr_gate
   import secreg_pkg::*;
#(
   parameter int              DATA_W  = 8,
   parameter int              ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] INT_TOP = 16'h1FFF
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              prog_mode_i,
   input  logic              inhibit_n_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              valid_o,
   output logic              viol_o,
   output logic [DATA_W-1:0] data_o
);

   logic exec_int;
   logic tgt_int;
   logic accept;
   logic block;

   assign exec_int = in_internal(16'(pc_i), 16'(INT_TOP));
   assign tgt_int  = in_internal(16'(addr_i), 16'(INT_TOP));
   assign accept   = req_i && !prog_mode_i;
   assign block    = !inhibit_n_i && !exec_int && tgt_int;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         viol_o  <= 1'b0;
         data_o  <= '1;
      end else begin
         valid_o <= accept;
         viol_o  <= accept && block;
         data_o  <= (accept && !block) ? data_i : '1;
      end
   end

   // R12: a violation is only flagged on a result cycle
   p_viol_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |-> valid_o);

   // R9: a blocked result carries all ones
   p_block_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      viol_o |-> (data_o == '1));

   // R13: requests in programming mode yield no result
   p_prog_no_result_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      prog_mode_i |=> !valid_o);

   // R8: internally executed reads are never flagged
   p_int_exec_ok_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && exec_int) |=> !viol_o);

endmodule

// File: rtl/codeguard_secreg.sv
module codeguard_secreg #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter logic [DATA_W-1:0] IMPL_MASK = 8'h87,
   parameter logic [ADDR_W-1:0] SEC_ADDR  = 16'hFFFF,
   parameter logic [ADDR_W-1:0] INT_TOP   = 16'h1FFF,
   parameter int LOCK_POS  = 0,
   parameter int INH_POS   = 1,
   parameter int ENC_POS   = 2,
   parameter int GAIN_POS  = 7
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              prog_mode_i,
   input  logic [ADDR_W-1:0] pm_addr_i,
   input  logic              pm_wr_i,
   input  logic [DATA_W-1:0] pm_wdata_i,
   input  logic              pm_erase_i,
   input  logic [DATA_W-1:0] pm_array_i,
   output logic [DATA_W-1:0] pm_rdata_o,
   input  logic              tr_req_i,
   input  logic [ADDR_W-1:0] tr_pc_i,
   input  logic [ADDR_W-1:0] tr_addr_i,
   input  logic [DATA_W-1:0] tr_data_i,
   output logic              tr_valid_o,
   output logic [DATA_W-1:0] tr_data_o,
   output logic              tr_viol_o,
   output logic              lock_o,
   output logic              enc_en_o,
   output logic              half_gain_o
);

   localparam int POS_MAX = DATA_W - 1;

   if (LOCK_POS > POS_MAX || INH_POS > POS_MAX || ENC_POS > POS_MAX || GAIN_POS > POS_MAX) begin : g_bad_pos
      $error("control bit position outside register width");
   end
   if (!(IMPL_MASK[LOCK_POS] && IMPL_MASK[INH_POS] && IMPL_MASK[ENC_POS] && IMPL_MASK[GAIN_POS])) begin : g_bad_mask
      $error("control bit not marked as implemented");
   end
   if (ADDR_W > 16) begin : g_bad_addr
      $error("address width above 16 not supported");
   end

   logic [DATA_W-1:0] sec;

   secreg_store #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK),
      .SEC_ADDR(SEC_ADDR), .LOCK_POS(LOCK_POS)
   ) u_store (
      .clk_i(clk_i), .rst_ni(rst_ni), .prog_mode_i(prog_mode_i),
      .wr_i(pm_wr_i), .erase_i(pm_erase_i), .addr_i(pm_addr_i),
      .wdata_i(pm_wdata_i), .sec_o(sec)
   );

   secreg_pm_read #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR), .LOCK_POS(LOCK_POS)
   ) u_pm_read (
      .prog_mode_i(prog_mode_i), .addr_i(pm_addr_i), .sec_i(sec),
      .array_i(pm_array_i), .rdata_o(pm_rdata_o)
   );

   secreg_tr_gate #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INT_TOP(INT_TOP)
   ) u_tr_gate (
      .clk_i(clk_i), .rst_ni(rst_ni), .prog_mode_i(prog_mode_i),
      .inhibit_n_i(sec[INH_POS]), .req_i(tr_req_i), .pc_i(tr_pc_i),
      .addr_i(tr_addr_i), .data_i(tr_data_i), .valid_o(tr_valid_o),
      .viol_o(tr_viol_o), .data_o(tr_data_o)
   );

   assign lock_o      = !sec[LOCK_POS];
   assign enc_en_o    = !sec[ENC_POS];
   assign half_gain_o = !sec[GAIN_POS];

   // R6: locked reads in programming mode return all ones
   p_locked_ones_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_mode_i && lock_o) |-> (pm_rdata_o == '1));

   // R4: reserved positions read back as ones while unlocked
   p_rsvd_ones_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (prog_mode_i && !lock_o && pm_addr_i == SEC_ADDR) |-> ((pm_rdata_o | IMPL_MASK) == '1));

endmodule

// File: tb/codeguard_secreg_tb.sv
module codeguard_secreg_tb;

   typedef struct packed {
      logic [7:0] data;
      logic       viol;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_mode = 1'b0;
   logic [15:0] pm_addr = 16'h0;
   logic        pm_wr = 1'b0;
   logic [7:0]  pm_wdata = 8'h0;
   logic        pm_erase = 1'b0;
   logic [7:0]  pm_array = 8'h5A;
   logic [7:0]  pm_rdata;
   logic        tr_req = 1'b0;
   logic [15:0] tr_pc = 16'h0;
   logic [15:0] tr_addr = 16'h0;
   logic [7:0]  tr_data_in = 8'h0;
   logic        tr_valid;
   logic [7:0]  tr_data;
   logic        tr_viol;
   logic        lock, enc_en, half_gain;

   int   n_chk = 0;
   int   n_bad = 0;
   int   cycles = 0;
   bit   done = 1'b0;
   logic [7:0] sec_m = 8'hFF;
   exp_t exp_q[$];

   always #2 clk = ~clk;

   codeguard_secreg u_dut (
      .clk_i(clk), .rst_ni(rst_n), .prog_mode_i(prog_mode),
      .pm_addr_i(pm_addr), .pm_wr_i(pm_wr), .pm_wdata_i(pm_wdata),
      .pm_erase_i(pm_erase), .pm_array_i(pm_array), .pm_rdata_o(pm_rdata),
      .tr_req_i(tr_req), .tr_pc_i(tr_pc), .tr_addr_i(tr_addr),
      .tr_data_i(tr_data_in), .tr_valid_o(tr_valid), .tr_data_o(tr_data),
      .tr_viol_o(tr_viol), .lock_o(lock), .enc_en_o(enc_en),
      .half_gain_o(half_gain)
   );

   task automatic check8(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // program operation; the model follows the requirements R2, R4, R5
   task automatic pm_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      pm_addr = a; pm_wdata = d; pm_wr = 1'b1;
      if (prog_mode && a == 16'hFFFF && sec_m[0]) sec_m = (sec_m & d) | 8'h78;
      @(negedge clk);
      pm_wr = 1'b0;
   endtask

   task automatic pm_do_erase();
      @(negedge clk);
      pm_erase = 1'b1;
      if (prog_mode) sec_m = 8'hFF;
      @(negedge clk);
      pm_erase = 1'b0;
   endtask

   task automatic pm_read(input string tag, input logic [15:0] a, input logic [7:0] exp);
      @(negedge clk);
      pm_addr = a;
      #1 check8(tag, pm_rdata, exp);
   endtask

   // table read driver: pushes the expected result for the scoreboard
   task automatic tr_issue(input logic [15:0] pc, input logic [15:0] a, input logic [7:0] d);
      exp_t e;
      logic blk;
      @(negedge clk);
      tr_req = 1'b1; tr_pc = pc; tr_addr = a; tr_data_in = d;
      blk = !sec_m[1] && (pc > 16'h1FFF) && (a <= 16'h1FFF);
      e.viol = blk;
      e.data = blk ? 8'hFF : d;
      if (!prog_mode) exp_q.push_back(e);
   endtask

   task automatic tr_idle();
      @(negedge clk);
      tr_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_status(input string tag);
      #1;
      check8({tag, " lock"},  {7'b0, lock},      {7'b0, !sec_m[0]});
      check8({tag, " enc"},   {7'b0, enc_en},    {7'b0, !sec_m[2]});
      check8({tag, " gain"},  {7'b0, half_gain}, {7'b0, !sec_m[7]});
   endtask

   // monitor: pops and compares each table read result (R8..R13)
   always @(negedge clk) begin
      if (rst_n && tr_valid) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R13: unexpected result data %h viol %b expected none", tr_data, tr_viol);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (tr_data !== e.data || tr_viol !== e.viol) begin
               n_bad++;
               $display("FAIL R8-R11 table read: got %h/%b expected %h/%b", tr_data, tr_viol, e.data, e.viol);
            end
         end
      end else if (rst_n && tr_viol) begin
         n_chk++; n_bad++;
         $display("FAIL R12: viol without valid got 1 expected 0");
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      prog_mode = 1'b1;
      pm_read("R1 reg", 16'hFFFF, 8'hFF);
      chk_status("R1");
      check8("R1 valid", {7'b0, tr_valid}, 8'h00);
      pm_read("R7 array", 16'h0123, 8'h5A);
      // R11: inhibit=1 allows external exec reading internal code
      prog_mode = 1'b0;
      pm_read("R7 normal", 16'hFFFF, 8'hFF);
      tr_issue(16'h4000, 16'h0100, 8'h11);
      tr_issue(16'h2000, 16'h1FFF, 8'h12);
      tr_idle();
      // R2: program clears bit 1; writing ones sets nothing
      prog_mode = 1'b1;
      pm_write(16'hFFFF, 8'hFD);
      pm_read("R2 clear", 16'hFFFF, 8'hFD);
      pm_write(16'hFFFF, 8'hFF);
      pm_read("R2 no set", 16'hFFFF, 8'hFD);
      // R5: other address does not touch the register
      pm_write(16'h1234, 8'h00);
      pm_read("R5 other addr", 16'hFFFF, 8'hFD);
      // R5: write and erase ignored in normal mode
      prog_mode = 1'b0;
      pm_write(16'hFFFF, 8'h00);
      pm_do_erase();
      prog_mode = 1'b1;
      pm_read("R5 normal ignored", 16'hFFFF, 8'hFD);
      // R9, R10, R8 with inhibit active, boundaries on both addresses
      prog_mode = 1'b0;
      tr_issue(16'h4000, 16'h0100, 8'h21);
      tr_issue(16'h2000, 16'h1FFF, 8'h22);
      tr_issue(16'h2000, 16'h2000, 8'h23);
      tr_issue(16'h1FFF, 16'h0000, 8'h24);
      tr_issue(16'h0000, 16'hF000, 8'h25);
      tr_idle();
      // R13: requests in programming mode are ignored
      prog_mode = 1'b1;
      tr_issue(16'h4000, 16'h0100, 8'h31);
      tr_idle();
      check8("R13 queue", 8'(exp_q.size()), 8'h00);
      // R4 reserved bits, R14 gain output
      pm_write(16'hFFFF, 8'h07);
      pm_read("R4 rsvd", 16'hFFFF, 8'h7D);
      chk_status("R14 gain");
      // R6 lock
      pm_write(16'hFFFF, 8'hFE);
      chk_status("R14 lock");
      pm_read("R6 reg", 16'hFFFF, 8'hFF);
      pm_read("R6 array", 16'h0040, 8'hFF);
      // R5: locked writes ignored, seen on enc output
      pm_write(16'hFFFF, 8'hFB);
      chk_status("R5 locked");
      // R3 erase
      pm_do_erase();
      pm_read("R3 erase", 16'hFFFF, 8'hFF);
      chk_status("R3");
      // R3: erase wins over a same-cycle write
      @(negedge clk);
      pm_addr = 16'hFFFF; pm_wdata = 8'h00; pm_wr = 1'b1; pm_erase = 1'b1;
      sec_m = 8'hFF;
      @(negedge clk);
      pm_wr = 1'b0; pm_erase = 1'b0;
      pm_read("R3 priority", 16'hFFFF, 8'hFF);
      // R14 encryption output
      pm_write(16'hFFFF, 8'hFB);
      chk_status("R14 enc");
      prog_mode = 1'b0;
      tr_issue(16'h8000, 16'h0800, 8'h41);
      tr_idle();
      check8("R8 drained", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule